// File: doc/BRIEF.md
# Indexed Interrupt Redirection Table

This block routes interrupt requests from a set of device-side input pins to a downstream delivery bus. Every pin owns a 64-bit redirection entry. Software reaches the entries indirectly: it first writes an entry selector into a select register, then reads or writes a 32-bit data window, so that each entry is accessed as two halves. The entry tells the block how to treat the pin (edge or level sensitive, masked or not) and what to send when the pin fires: target, target addressing mode, delivery mode, vector and polarity.

Pin activity arrives as indexed level updates: a strobe, a pin number and the new level. The block keeps the last level of every pin and a pending flag for edge-sensitive pins. A scan pointer walks the pins in ascending order, one pin per clock, wrapping after the last one. When the pin under the pointer is pending and unmasked, the block places a delivery request on a valid/ready output. Edge-sensitive pins lose their pending flag when their request is issued. Level-sensitive pins stay pending for as long as their input is high, so they are delivered again on every lap. While a request waits for ready, the pointer stops and the request is held unchanged.

Top module: `irq_redirect_table`

## Requirements
- R1: After reset every entry reads back with its low half equal to 0x00010000 (only the mask bit set) and its high half equal to 0, the ID reads 0 and no delivery is offered.
- R2: A bus write to offset 0x00 loads the select register from write data bits [7:0]; a read of offset 0x00 returns the select value in bits [7:0]; offset 0x10 is the data window addressed by the select value.
- R3: With select 0x00 the window reads the ID in bits [31:24] (other bits 0), and a window write loads the ID from write data bits [31:24]; with select 0x01 the window reads 0x11 in bits [7:0] and the pin count minus one in bits [23:16] (0x00170011 for 24 pins), and writes there change nothing.
- R4: A select value s of 0x10 or more reaches entry (s-0x10)>>1, the low 32 bits when s is even and the high 32 bits when s is odd; selects beyond the last entry, and selects 0x02 to 0x0F, read 0.
- R5: A delivery carries vector = entry bits [7:0], delivery mode = bits [10:8], destination mode = bit 11, polarity = bit 13, trigger = bit 15 and destination = bits [63:56].
- R6: For an entry with bit 15 clear (edge), a pin update from low to high makes the pin pending; exactly one delivery follows, and a further update that keeps the pin high issues nothing.
- R7: For an entry with bit 15 set (level), the pin is pending exactly while its last reported level is high, so it is delivered repeatedly while high and not at all once low.
- R8: An entry with bit 16 set issues nothing; an edge that arrived while masked stays pending and is delivered once bit 16 is cleared.
- R9: Pin updates whose pin number is 24 or above change no pin state and cause no delivery.
- R10: Pending pins are served in ascending pin order from the scan pointer, one pin examined per clock.
- R11: While a delivery is offered and ready is low, the request and the scan pointer hold still, and edges arriving on other pins meanwhile are kept and delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 8 | Bus offset: 0x00 select register, 0x10 data window |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| pin_we | input | 1 | Pin level update strobe |
| pin_idx | input | 5 | Number of the pin being updated |
| pin_level | input | 1 | New level of that pin |
| dlv_valid | output | 1 | Delivery request offered |
| dlv_ready | input | 1 | Downstream accepts the request |
| dlv_dest | output | 8 | Destination field |
| dlv_dest_mode | output | 1 | Destination addressing mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_polarity | output | 1 | Input polarity bit of the entry |
| dlv_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
A corrupted pending flag shows up at the delivery port within one scan lap, at most 24 cycles after the pointer passes the pin: a lost edge means a missing delivery, a stale one means an extra delivery that the scoreboard has not been told to expect. A wrong scan pointer or a leaky stall shows as deliveries out of ascending order or as a payload that changes while ready is low. Errors in the select decoding show on the very next window read, as data from the wrong half or the wrong entry.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
package irt_pkg;
  // entry field positions, decoded by the delivery side
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int POL_BIT   = 13;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  localparam logic [7:0] IRT_VERSION = 8'h11;
  localparam logic [7:0] ADDR_SEL    = 8'h00;
  localparam logic [7:0] ADDR_WIN    = 8'h10;
  localparam logic [7:0] SEL_ID      = 8'h00;
  localparam logic [7:0] SEL_VER     = 8'h01;
  localparam logic [7:0] SEL_TBL     = 8'h10;
  localparam logic [31:0] LO_RESET   = 32'h0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic [7:0] vector;
    logic [2:0] mode;
    logic       dmode;
    logic       pol;
    logic       trig;
  } dlv_t;

  function automatic dlv_t unpack_entry(input logic [63:0] e);
    dlv_t d;
    d.dest   = e[DEST_LSB +: 8];
    d.vector = e[VEC_LSB +: 8];
    d.mode   = e[MODE_LSB +: 3];
    d.dmode  = e[DMODE_BIT];
    d.pol    = e[POL_BIT];
    d.trig   = e[TRIG_BIT];
    return d;
  endfunction
endpackage

// File: rtl/irt_entry_ram.sv
`timescale 1ns/1ps
module irt_entry_ram
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          whi,
  input  logic [IW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ra_a,
  input  logic [IW-1:0] ra_b,
  input  logic [IW-1:0] ra_c,
  output logic [63:0]   rd_a,
  output logic [63:0]   rd_b,
  output logic [63:0]   rd_c
);
  logic [31:0] lo_q [NPINS];
  logic [31:0] hi_q [NPINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= '0;
      end
    end else if (we) begin
      if (whi) hi_q[waddr] <= wdata;
      else     lo_q[waddr] <= wdata;
    end
  end

  assign rd_a = {hi_q[ra_a], lo_q[ra_a]};
  assign rd_b = {hi_q[ra_b], lo_q[ra_b]};
  assign rd_c = {hi_q[ra_c], lo_q[ra_c]};

  // R4: a low-half write is visible through the bus read port next cycle
  p_low_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (we && !whi && (ra_a == waddr)) |=> (rd_a[31:0] == $past(wdata)));
endmodule

// File: rtl/irt_bus_regs.sv
`timescale 1ns/1ps
module irt_bus_regs
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          ram_we,
  output logic          ram_whi,
  output logic [IW-1:0] ram_addr,
  output logic [31:0]   ram_wdata,
  input  logic [63:0]   ram_rdata
);
  localparam logic [7:0]  LAST_PIN = 8'(NPINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, LAST_PIN, 8'h00, IRT_VERSION};

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [31:0] rdata_q;
  logic [7:0]  rel;
  logic [7:0]  ent_idx;
  logic        tbl_hit;
  logic [31:0] win_data;

  assign rel     = sel_q - SEL_TBL;
  assign ent_idx = {1'b0, rel[7:1]};
  assign tbl_hit = (sel_q >= SEL_TBL) && (ent_idx < 8'(NPINS));

  assign ram_addr  = tbl_hit ? ent_idx[IW-1:0] : '0;
  assign ram_whi   = sel_q[0];
  assign ram_wdata = bus_wdata;
  assign ram_we    = bus_wr && (bus_addr == ADDR_WIN) && tbl_hit;

  always_comb begin
    if (sel_q == SEL_ID)       win_data = {id_q, 24'h0};
    else if (sel_q == SEL_VER) win_data = VER_WORD;
    else if (tbl_hit)          win_data = sel_q[0] ? ram_rdata[63:32] : ram_rdata[31:0];
    else                       win_data = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      id_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_SEL) sel_q <= bus_wdata[7:0];
      if (bus_wr && bus_addr == ADDR_WIN && sel_q == SEL_ID) id_q <= bus_wdata[31:24];
      if (bus_rd) begin
        if (bus_addr == ADDR_SEL)      rdata_q <= {24'h0, sel_q};
        else if (bus_addr == ADDR_WIN) rdata_q <= win_data;
        else                           rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;

  // R2: select register takes the low byte of a write to offset 0
  p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_SEL) |=> (sel_q == $past(bus_wdata[7:0])));
  // R3: ID takes the top byte of a window write while select is 0
  p_id_write_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_WIN && sel_q == SEL_ID) |=> (id_q == $past(bus_wdata[31:24])));
endmodule

// File: rtl/irt_pending.sv
`timescale 1ns/1ps
module irt_pending
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_we,
  input  logic [IW-1:0] pin_idx,
  input  logic          pin_level,
  input  logic          pin_is_level,
  input  logic          clr,
  input  logic [IW-1:0] clr_idx,
  input  logic [IW-1:0] scan_idx,
  input  logic          scan_is_level,
  output logic          scan_pend
);
  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] edge_q;
  logic [NPINS-1:0] clr_mask;
  logic             pin_ok;

  assign pin_ok = pin_we && (pin_idx < IW'(NPINS));

  always_comb begin
    clr_mask = '0;
    if (clr) clr_mask[clr_idx] = 1'b1;
  end

  // a new edge on the pin being cleared wins, so it is never lost
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      edge_q <= '0;
    end else begin
      edge_q <= edge_q & ~clr_mask;
      if (pin_ok) begin
        lvl_q[pin_idx] <= pin_level;
        if (pin_level && !lvl_q[pin_idx] && !pin_is_level)
          edge_q[pin_idx] <= 1'b1;
      end
    end
  end

  assign scan_pend = scan_is_level ? lvl_q[scan_idx] : edge_q[scan_idx];

  // R6, R11: an edge flag is only ever dropped by the scanner's clear
  p_edge_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (($past(edge_q) & ~$past(clr_mask) & ~edge_q) == '0));
  // R7: the stored level follows every in-range update
  p_level_follows_r7: assert property (@(posedge clk) disable iff (rst)
    pin_ok |=> (lvl_q[$past(pin_idx)] == $past(pin_level)));
  // R9: out-of-range pin numbers leave the levels alone
  p_pin_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (pin_we && !pin_ok) |=> $stable(lvl_q));
endmodule

// File: rtl/irt_scan.sv
`timescale 1ns/1ps
module irt_scan
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [63:0]   ent,
  input  logic          pend,
  output logic [IW-1:0] idx,
  output logic          clr,
  output logic          dlv_valid,
  input  logic          dlv_ready,
  output dlv_t          dlv
);
  localparam logic [IW-1:0] LAST = IW'(NPINS - 1);

  logic [IW-1:0] idx_q;
  logic          v_q;
  dlv_t          pay_q;
  logic          held;
  logic          elig;

  assign held = v_q && !dlv_ready;
  assign elig = pend && !ent[MASK_BIT];
  assign clr  = !held && elig && !ent[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      v_q   <= 1'b0;
      pay_q <= '0;
    end else if (!held) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      v_q   <= elig;
      if (elig) pay_q <= unpack_entry(ent);
    end
  end

  assign idx       = idx_q;
  assign dlv_valid = v_q;
  assign dlv       = pay_q;

  // R11: a stalled request keeps valid and payload
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && dlv == $past(dlv)));
  // R11: the pointer freezes during a stall
  p_scan_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (idx == $past(idx)));
  // R10: the pointer never leaves the table
  p_idx_range_r10: assert property (@(posedge clk) disable iff (rst)
    (idx < IW'(NPINS)));
endmodule

// File: rtl/irq_redirect_table.sv
`timescale 1ns/1ps
module irq_redirect_table
  import irt_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IW    = $clog2(NPINS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          pin_we,
  input  logic [IW-1:0] pin_idx,
  input  logic          pin_level,
  output logic          dlv_valid,
  input  logic          dlv_ready,
  output logic [7:0]    dlv_dest,
  output logic          dlv_dest_mode,
  output logic [2:0]    dlv_mode,
  output logic [7:0]    dlv_vector,
  output logic          dlv_polarity,
  output logic          dlv_trigger
);
  logic          ram_we, ram_whi;
  logic [IW-1:0] ram_addr;
  logic [31:0]   ram_wdata;
  logic [63:0]   bus_ent, scan_ent, pin_ent;
  logic [IW-1:0] pin_raddr, scan_idx;
  logic          scan_pend, clr;
  dlv_t          dlv;

  assign pin_raddr = (pin_idx < IW'(NPINS)) ? pin_idx : '0;

  irt_bus_regs #(.NPINS(NPINS), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_we(ram_we), .ram_whi(ram_whi), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(bus_ent));

  irt_entry_ram #(.NPINS(NPINS), .IW(IW)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .whi(ram_whi), .waddr(ram_addr),
    .wdata(ram_wdata), .ra_a(ram_addr), .ra_b(scan_idx), .ra_c(pin_raddr),
    .rd_a(bus_ent), .rd_b(scan_ent), .rd_c(pin_ent));

  irt_pending #(.NPINS(NPINS), .IW(IW)) u_pend (
    .clk(clk), .rst(rst), .pin_we(pin_we), .pin_idx(pin_idx),
    .pin_level(pin_level), .pin_is_level(pin_ent[TRIG_BIT]),
    .clr(clr), .clr_idx(scan_idx), .scan_idx(scan_idx),
    .scan_is_level(scan_ent[TRIG_BIT]), .scan_pend(scan_pend));

  irt_scan #(.NPINS(NPINS), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .ent(scan_ent), .pend(scan_pend), .idx(scan_idx),
    .clr(clr), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv(dlv));

  assign dlv_dest      = dlv.dest;
  assign dlv_dest_mode = dlv.dmode;
  assign dlv_mode      = dlv.mode;
  assign dlv_vector    = dlv.vector;
  assign dlv_polarity  = dlv.pol;
  assign dlv_trigger   = dlv.trig;

  // R1: nothing is offered in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !dlv_valid);
endmodule

// File: tb/sim_irq_redirect_table.sv
`timescale 1ns/1ps
module sim_irq_redirect_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        pin_we = 0, pin_level = 0;
  logic [4:0]  pin_idx = 0;
  logic        dlv_valid, dlv_ready = 1'b1;
  logic [7:0]  dlv_dest, dlv_vector;
  logic        dlv_dest_mode, dlv_polarity, dlv_trigger;
  logic [2:0]  dlv_mode;

  int n_vec = 0, n_bad = 0, got = 0, pushed = 0, lvl_count = 0;
  bit lvl_mode = 0, done = 0;
  logic [21:0] expq[$];

  always #2.5 clk = ~clk;

  irq_redirect_table u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_we(pin_we),
    .pin_idx(pin_idx), .pin_level(pin_level), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
    .dlv_mode(dlv_mode), .dlv_vector(dlv_vector), .dlv_polarity(dlv_polarity),
    .dlv_trigger(dlv_trigger));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input logic [7:0] d, input logic [7:0] v,
      input logic [2:0] m, input logic dm, input logic p, input logic t);
    return {d, v, m, dm, p, t};
  endfunction

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1 bus_rd = 1; bus_addr = a;
    @(posedge clk); #1 bus_rd = 0; d = bus_rdata;
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    bwr(8'h00, {24'h0, s});
    brd(8'h10, d);
  endtask

  task automatic set_entry(input int n, input logic [31:0] lo, input logic [31:0] hi);
    bwr(8'h00, 32'h10 + 2 * n + 1); bwr(8'h10, hi);
    bwr(8'h00, 32'h10 + 2 * n);     bwr(8'h10, lo);
  endtask

  task automatic pin(input int n, input logic l);
    @(posedge clk); #1 pin_we = 1; pin_idx = 5'(n); pin_level = l;
    @(posedge clk); #1 pin_we = 0;
  endtask

  task automatic push(input logic [21:0] e);
    expq.push_back(e); pushed++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dlv_valid && dlv_ready) begin
      if (lvl_mode && dlv_vector == 8'h45) lvl_count++;
      else if (expq.size() == 0)
        chk("R6/R8/R9 unexpected delivery", {42'h0, dlv_dest, dlv_vector, dlv_mode,
            dlv_dest_mode, dlv_polarity, dlv_trigger}, 64'h0);
      else begin
        chk("R5/R10 delivery payload", {42'h0, dlv_dest, dlv_vector, dlv_mode,
            dlv_dest_mode, dlv_polarity, dlv_trigger}, {42'h0, expq.pop_front()});
        got++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(4); rst = 0; idle(1);
    chk("R1 no delivery after reset", dlv_valid, 0);
    win_rd(8'h00, d); chk("R1 ID zero", d, 0);
    win_rd(8'h10, d); chk("R1 entry 0 low", d, 32'h0001_0000);
    win_rd(8'h3F, d); chk("R1 entry 23 high", d, 0);
    win_rd(8'h3E, d); chk("R1 entry 23 low", d, 32'h0001_0000);
    win_rd(8'h01, d); chk("R3 version word", d, 32'h0017_0011);

    bwr(8'h00, 32'hFFFF_FF2A); brd(8'h00, d); chk("R2 select readback", d, 32'h2A);
    bwr(8'h00, 0); bwr(8'h10, 32'hABCD_EF12); brd(8'h10, d); chk("R3 ID write", d, 32'hAB00_0000);
    bwr(8'h00, 1); bwr(8'h10, 32'h1234_5678); brd(8'h10, d); chk("R3 version read-only", d, 32'h0017_0011);

    set_entry(5, 32'h0000_2931, 32'h5C00_0000);
    win_rd(8'h1A, d); chk("R4 entry 5 low (even select)", d, 32'h0000_2931);
    win_rd(8'h1B, d); chk("R4 entry 5 high (odd select)", d, 32'h5C00_0000);
    win_rd(8'h40, d); chk("R4 select past table", d, 0);
    win_rd(8'h05, d); chk("R4 reserved select", d, 0);

    // R5, R6: edge pin delivers once
    push(mk(8'h5C, 8'h31, 3'd1, 1, 1, 0));
    pin(5, 1); idle(40);
    chk("R6 one edge delivery", got, pushed);
    pin(5, 1); idle(40);
    chk("R6 held high no repeat", got, pushed);

    // R7: level pin
    set_entry(7, 32'h0000_8045, 32'h1100_0000);
    lvl_mode = 1; lvl_count = 0;
    pin(7, 1); idle(80);
    chk("R7 level repeats while high", lvl_count >= 2, 1);
    pin(7, 0); idle(30); lvl_count = 0; idle(60);
    chk("R7 level silent when low", lvl_count, 0);
    lvl_mode = 0;

    // R8: masked edge kept until unmask
    set_entry(9, 32'h0001_0052, 32'h2200_0000);
    pin(9, 1); idle(40);
    chk("R8 masked no delivery", got, pushed);
    push(mk(8'h22, 8'h52, 3'd0, 0, 0, 0));
    set_entry(9, 32'h0000_0052, 32'h2200_0000); idle(40);
    chk("R8 delivered after unmask", got, pushed);

    // R9: out-of-range pin numbers
    set_entry(0, 32'h0000_0060, 32'h0);
    set_entry(8, 32'h0000_0068, 32'h0);
    pin(24, 1); pin(31, 1); idle(40);
    chk("R9 out-of-range pins ignored", got, pushed);
    push(mk(8'h00, 8'h60, 3'd0, 0, 0, 0));
    pin(0, 1); idle(40);
    chk("R9 pin 0 still fresh", got, pushed);

    // R10, R11: stall and ascending order
    set_entry(1, 32'h0000_0071, 32'h0100_0000);
    set_entry(4, 32'h0000_0074, 32'h0400_0000);
    set_entry(13, 32'h0000_007D, 32'h0D00_0000);
    set_entry(20, 32'h0000_0084, 32'h1400_0000);
    dlv_ready = 0;
    pin(1, 1); idle(30);
    chk("R11 stalled request offered", {dlv_valid, dlv_vector}, {1'b1, 8'h71});
    pin(20, 1); pin(4, 1); pin(13, 1); idle(10);
    chk("R11 payload held during stall", {dlv_valid, dlv_vector, dlv_dest}, {1'b1, 8'h71, 8'h01});
    push(mk(8'h01, 8'h71, 3'd0, 0, 0, 0));
    push(mk(8'h04, 8'h74, 3'd0, 0, 0, 0));
    push(mk(8'h0D, 8'h7D, 3'd0, 0, 0, 0));
    push(mk(8'h14, 8'h84, 3'd0, 0, 0, 0));
    dlv_ready = 1; idle(60);
    chk("R10 all four served in order", got, pushed);
    chk("R11 nothing left offered", dlv_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule